// File: doc/BRIEF.md
# Interrupt-Capable GPIO Port Controller

This block is a 16-pin general-purpose I/O port behind a simple memory-mapped register bus. The bus uses APB-style select and enable phases and carries 16-bit data. Each pin has a direction bit and an output-data bit. Software can change the output bits in three ways: load the whole word, set chosen bits through a write-one register, or clear chosen bits through a second write-one register. Input pins pass through a two-flop synchroniser, and the synchronised levels can be read back as a single word.

Each pin can raise an interrupt in one of two ways. In level mode it responds to a high or a low level, chosen per pin. In edge mode it responds to a rising edge, a falling edge or both. Edge events are latched until software acknowledges them. Level events are not latched: they follow the pin as it is now. A pin reaches the interrupt only when it is unmasked and enabled. Software reads a masked-status word to find the pins that need service, then acknowledges edge events by writing ones to a clear register. All pending pins are combined into one registered interrupt line.

Top module: `gpio_irq_port`

## Requirements
- R1: After reset, pin_oe, pin_out and irq_out are all 0. The mask register (0x28) reads 0xFFFF, and the enable register (0x2C) and the masked-status register (0x30) read 0.
- R2: A 1 in bit i of the direction register (0x00) drives pin_oe[i] high, which makes the pin an output. A 0 makes it an input. pin_oe changes only when the direction register is written. The output word at 0x20 reads back as written and drives pin_out.
- R3: Writing 0x18 forces to 1 every output bit written as 1. Writing 0x1C forces to 0 every output bit written as 1. Bits written as 0 in either register keep their value.
- R4: Offset 0x14 returns the level of each pin, synchronised through two flops. The configuration words at 0x04, 0x08, 0x0C, 0x10, 0x28 and 0x2C read back as written.
- R5: When bit i of 0x04 is 1, pin i is level-sensitive. It is pending while its synchronised level equals bit i of 0x08 (1 = active high, 0 = active low). When the level goes away, the pending state drops with no acknowledge.
- R6: When bit i of 0x04 is 0, a rising edge latches an event if bit i of 0x0C is 1, and a falling edge latches an event if bit i of 0x10 is 1. With both bits set, the pin fires on both edges. With neither bit set, edges are ignored.
- R7: A latched edge event stays pending until a 1 is written to its bit of the clear register (0x34). Writing 0 to that bit leaves the event in place.
- R8: If an edge arrives in the same cycle as a clear of the same bit, the new event stays latched.
- R9: Bit i of the masked-status register (0x30) is 1 only when pin i is pending, bit i of the mask register is 0, and bit i of the enable register is 1.
- R10: irq_out equals the OR of the masked-status bits, delayed by one clock.
- R11: Reads from unmapped offsets, and reads of the write-only offsets 0x18, 0x1C and 0x34, return 0. A write to an unmapped offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| psel | input | 1 | Bus select |
| penable | input | 1 | Bus access phase |
| pwrite | input | 1 | 1 = write, 0 = read |
| paddr | input | 8 | Byte offset of the register |
| pwdata | input | 16 | Write data |
| prdata | output | 16 | Read data, valid while psel is high |
| pin_in | input | 16 | Raw pin levels |
| pin_out | output | 16 | Output data toward the pads |
| pin_oe | output | 16 | Output enable, one bit per pin |
| irq_out | output | 1 | Combined interrupt request |

## Verification
The bench lines up a falling edge with the acknowledge of the same bit, cycle for cycle. A design that lets the clear win would drop that event, and masked status would read 0 instead of the bit. It also drops a level from an active-high pin and checks that the pending bit clears with no acknowledge, which catches a design that wrongly latches level events. A pin armed only for falling edges is given a rising edge, and a latched event is acknowledged with a zero word; a design that decodes the edge enables or the clear incorrectly shows a stray or lost status bit. Mask and enable are toggled one at a time on a latched event, which exposes a design that gates the interrupt on only one of the two.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

  // Register byte offsets (software-visible map)
  localparam int unsigned OFS_DIR    = 'h00;
  localparam int unsigned OFS_LVLSEL = 'h04;
  localparam int unsigned OFS_LVLPOL = 'h08;
  localparam int unsigned OFS_RISEEN = 'h0C;
  localparam int unsigned OFS_FALLEN = 'h10;
  localparam int unsigned OFS_PINS   = 'h14;
  localparam int unsigned OFS_SET    = 'h18;
  localparam int unsigned OFS_CLR    = 'h1C;
  localparam int unsigned OFS_OUT    = 'h20;
  localparam int unsigned OFS_MASK   = 'h28;
  localparam int unsigned OFS_EN     = 'h2C;
  localparam int unsigned OFS_PEND   = 'h30;
  localparam int unsigned OFS_ACK    = 'h34;

  // Next value of one output bit under word load, set and clear strobes
  function automatic logic out_bit_next(input logic cur, input logic load,
                                        input logic load_val, input logic set_b,
                                        input logic clr_b);
    logic nv;
    nv = load ? load_val : cur;
    if (set_b) nv = 1'b1;
    if (clr_b) nv = 1'b0;
    return nv;
  endfunction

  // Edge event for one pin from the current and previous synchronised level
  function automatic logic edge_fire(input logic cur, input logic prev,
                                     input logic rise_en, input logic fall_en);
    return (rise_en & cur & ~prev) | (fall_en & ~cur & prev);
  endfunction

  // Level match for one pin: polarity 1 = active high, 0 = active low
  function automatic logic level_fire(input logic cur, input logic pol);
    return ~(cur ^ pol);
  endfunction

  // Latched event bit: a new event dominates a clear in the same cycle
  function automatic logic evt_next(input logic held, input logic clr_b,
                                    input logic fire);
    return (held & ~clr_b) | fire;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] lvl_now,
  output logic [N_PINS-1:0] lvl_prev
);
  localparam int unsigned LAST = STAGES - 1;

  logic [N_PINS-1:0] chain [STAGES];
  logic [N_PINS-1:0] prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= pin_in;
        end
      end else begin : g_rest
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) chain[s] <= '0;
          else        chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= chain[LAST];
  end

  assign lvl_now  = chain[LAST];
  assign lvl_prev = prev_q;
endmodule

// File: rtl/gpio_ctl_regs.sv
module gpio_ctl_regs
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [N_PINS-1:0] pwdata,
  output logic [N_PINS-1:0] prdata,
  input  logic [N_PINS-1:0] lvl_now,
  input  logic [N_PINS-1:0] masked_stat,
  output logic [N_PINS-1:0] dir_q,
  output logic [N_PINS-1:0] out_q,
  output logic [N_PINS-1:0] lvlsel_q,
  output logic [N_PINS-1:0] lvlpol_q,
  output logic [N_PINS-1:0] riseen_q,
  output logic [N_PINS-1:0] fallen_q,
  output logic [N_PINS-1:0] mask_q,
  output logic [N_PINS-1:0] en_q,
  output logic [N_PINS-1:0] ack_vec
);
  localparam logic [ADDR_W-1:0] A_DIR    = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_LVLSEL = ADDR_W'(OFS_LVLSEL);
  localparam logic [ADDR_W-1:0] A_LVLPOL = ADDR_W'(OFS_LVLPOL);
  localparam logic [ADDR_W-1:0] A_RISEEN = ADDR_W'(OFS_RISEEN);
  localparam logic [ADDR_W-1:0] A_FALLEN = ADDR_W'(OFS_FALLEN);
  localparam logic [ADDR_W-1:0] A_PINS   = ADDR_W'(OFS_PINS);
  localparam logic [ADDR_W-1:0] A_SET    = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR    = ADDR_W'(OFS_CLR);
  localparam logic [ADDR_W-1:0] A_OUT    = ADDR_W'(OFS_OUT);
  localparam logic [ADDR_W-1:0] A_MASK   = ADDR_W'(OFS_MASK);
  localparam logic [ADDR_W-1:0] A_EN     = ADDR_W'(OFS_EN);
  localparam logic [ADDR_W-1:0] A_PEND   = ADDR_W'(OFS_PEND);
  localparam logic [ADDR_W-1:0] A_ACK    = ADDR_W'(OFS_ACK);
  localparam logic [N_PINS-1:0] ALL_ONES = '1;

  logic wr_go;
  logic wr_dir, wr_lvlsel, wr_lvlpol, wr_riseen, wr_fallen;
  logic wr_set, wr_clr, wr_out, wr_mask, wr_en, wr_ack;
  logic [N_PINS-1:0] set_v, clr_v, out_nx;

  assign wr_go     = psel & penable & pwrite;
  assign wr_dir    = wr_go & (paddr == A_DIR);
  assign wr_lvlsel = wr_go & (paddr == A_LVLSEL);
  assign wr_lvlpol = wr_go & (paddr == A_LVLPOL);
  assign wr_riseen = wr_go & (paddr == A_RISEEN);
  assign wr_fallen = wr_go & (paddr == A_FALLEN);
  assign wr_set    = wr_go & (paddr == A_SET);
  assign wr_clr    = wr_go & (paddr == A_CLR);
  assign wr_out    = wr_go & (paddr == A_OUT);
  assign wr_mask   = wr_go & (paddr == A_MASK);
  assign wr_en     = wr_go & (paddr == A_EN);
  assign wr_ack    = wr_go & (paddr == A_ACK);

  assign set_v   = wr_set ? pwdata : '0;
  assign clr_v   = wr_clr ? pwdata : '0;
  assign ack_vec = wr_ack ? pwdata : '0;

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_outbit
      assign out_nx[i] = out_bit_next(out_q[i], wr_out, pwdata[i], set_v[i], clr_v[i]);
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q    <= '0;
      out_q    <= '0;
      lvlsel_q <= '0;
      lvlpol_q <= '0;
      riseen_q <= '0;
      fallen_q <= '0;
      mask_q   <= ALL_ONES;
      en_q     <= '0;
    end else begin
      out_q <= out_nx;
      if (wr_dir)    dir_q    <= pwdata;
      if (wr_lvlsel) lvlsel_q <= pwdata;
      if (wr_lvlpol) lvlpol_q <= pwdata;
      if (wr_riseen) riseen_q <= pwdata;
      if (wr_fallen) fallen_q <= pwdata;
      if (wr_mask)   mask_q   <= pwdata;
      if (wr_en)     en_q     <= pwdata;
    end
  end

  always_comb begin
    prdata = '0;
    if (psel) begin
      case (paddr)
        A_DIR:    prdata = dir_q;
        A_LVLSEL: prdata = lvlsel_q;
        A_LVLPOL: prdata = lvlpol_q;
        A_RISEEN: prdata = riseen_q;
        A_FALLEN: prdata = fallen_q;
        A_PINS:   prdata = lvl_now;
        A_OUT:    prdata = out_q;
        A_MASK:   prdata = mask_q;
        A_EN:     prdata = en_q;
        A_PEND:   prdata = masked_stat;
        default:  prdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq_detect.sv
module gpio_irq_detect
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_PINS-1:0] lvl_now,
  input  logic [N_PINS-1:0] lvl_prev,
  input  logic [N_PINS-1:0] lvlsel,
  input  logic [N_PINS-1:0] lvlpol,
  input  logic [N_PINS-1:0] riseen,
  input  logic [N_PINS-1:0] fallen,
  input  logic [N_PINS-1:0] mask,
  input  logic [N_PINS-1:0] en,
  input  logic [N_PINS-1:0] ack_vec,
  output logic [N_PINS-1:0] edge_hit,
  output logic [N_PINS-1:0] raw_evt,
  output logic [N_PINS-1:0] masked_stat,
  output logic              irq_q
);
  logic [N_PINS-1:0] lvl_hit;
  logic [N_PINS-1:0] pend;

  generate
    for (genvar i = 0; i < N_PINS; i++) begin : g_pin
      assign edge_hit[i] = ~lvlsel[i] &
                           edge_fire(lvl_now[i], lvl_prev[i], riseen[i], fallen[i]);
      assign lvl_hit[i]  = lvlsel[i] & level_fire(lvl_now[i], lvlpol[i]);
      assign pend[i]     = lvlsel[i] ? lvl_hit[i] : raw_evt[i];

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) raw_evt[i] <= 1'b0;
        else        raw_evt[i] <= evt_next(raw_evt[i], ack_vec[i], edge_hit[i]);
      end
    end
  endgenerate

  assign masked_stat = pend & ~mask & en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) irq_q <= 1'b0;
    else        irq_q <= |masked_stat;
  end
endmodule

// File: rtl/gpio_irq_port.sv
module gpio_irq_port #(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [N_PINS-1:0] pwdata,
  output logic [N_PINS-1:0] prdata,
  input  logic [N_PINS-1:0] pin_in,
  output logic [N_PINS-1:0] pin_out,
  output logic [N_PINS-1:0] pin_oe,
  output logic              irq_out
);
  logic [N_PINS-1:0] lvl_now, lvl_prev;
  logic [N_PINS-1:0] dir_q, out_q, lvlsel_q, lvlpol_q, riseen_q, fallen_q;
  logic [N_PINS-1:0] mask_q, en_q, ack_vec;
  logic [N_PINS-1:0] edge_hit, raw_evt, masked_stat;
  logic              irq_q;

  gpio_in_sync #(.N_PINS(N_PINS), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in),
    .lvl_now(lvl_now), .lvl_prev(lvl_prev)
  );

  gpio_ctl_regs #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .lvl_now(lvl_now), .masked_stat(masked_stat),
    .dir_q(dir_q), .out_q(out_q), .lvlsel_q(lvlsel_q), .lvlpol_q(lvlpol_q),
    .riseen_q(riseen_q), .fallen_q(fallen_q), .mask_q(mask_q), .en_q(en_q),
    .ack_vec(ack_vec)
  );

  gpio_irq_detect #(.N_PINS(N_PINS)) u_det (
    .clk(clk), .rst_n(rst_n),
    .lvl_now(lvl_now), .lvl_prev(lvl_prev),
    .lvlsel(lvlsel_q), .lvlpol(lvlpol_q),
    .riseen(riseen_q), .fallen(fallen_q),
    .mask(mask_q), .en(en_q), .ack_vec(ack_vec),
    .edge_hit(edge_hit), .raw_evt(raw_evt),
    .masked_stat(masked_stat), .irq_q(irq_q)
  );

  assign pin_out = out_q;
  assign pin_oe  = dir_q;
  assign irq_out = irq_q;
endmodule

// File: rtl/gpio_irq_port_chk.sv
module gpio_irq_port_chk
  import gpio_irq_pkg::*;
#(
  parameter int unsigned N_PINS = 16,
  parameter int unsigned ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              psel,
  input logic              penable,
  input logic              pwrite,
  input logic [ADDR_W-1:0] paddr,
  input logic [N_PINS-1:0] pwdata,
  input logic [N_PINS-1:0] pin_out,
  input logic [N_PINS-1:0] pin_oe,
  input logic              irq_out,
  input logic [N_PINS-1:0] masked_stat,
  input logic [N_PINS-1:0] edge_hit,
  input logic [N_PINS-1:0] raw_evt
);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_SET = ADDR_W'(OFS_SET);
  localparam logic [ADDR_W-1:0] A_CLR = ADDR_W'(OFS_CLR);

  logic wr_go;
  assign wr_go = psel & penable & pwrite;

  assert_dir_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(wr_go && paddr == A_DIR) |=> $stable(pin_oe));

  assert_set_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && paddr == A_SET) |=> ((pin_out & $past(pwdata)) == $past(pwdata)));

  assert_clr_ones_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_go && paddr == A_CLR) |=> ((pin_out & $past(pwdata)) == '0));

  assert_evt_source_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_evt & ~$past(raw_evt) & ~$past(edge_hit)) == '0);

  assert_edge_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (raw_evt & $past(edge_hit)) == $past(edge_hit));

  assert_irq_follow_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out == $past(|masked_stat));
endmodule

bind gpio_irq_port gpio_irq_port_chk #(.N_PINS(N_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .pin_out(pin_out), .pin_oe(pin_oe),
  .irq_out(irq_out), .masked_stat(masked_stat), .edge_hit(edge_hit),
  .raw_evt(raw_evt)
);

// File: tb/sim_gpio_irq_port.sv
module sim_gpio_irq_port;
  localparam int CLK_PERIOD = 10;

  localparam logic [7:0] O_DIR = 8'h00, O_LSEL = 8'h04, O_LPOL = 8'h08,
                         O_RISE = 8'h0C, O_FALL = 8'h10, O_PINS = 8'h14,
                         O_SET = 8'h18, O_CLR = 8'h1C, O_OUT = 8'h20,
                         O_MASK = 8'h28, O_EN = 8'h2C, O_PEND = 8'h30,
                         O_ACK = 8'h34;

  // {write offset, write data, read offset, expected read}
  localparam int NVEC = 14;
  localparam logic [47:0] VEC [NVEC] = '{
    {O_DIR,  16'hA5A5, O_DIR,  16'hA5A5},
    {O_OUT,  16'h1234, O_OUT,  16'h1234},
    {O_SET,  16'h00C0, O_OUT,  16'h12F4},
    {O_CLR,  16'h0204, O_OUT,  16'h10F0},
    {O_SET,  16'h0000, O_OUT,  16'h10F0},
    {O_CLR,  16'h0000, O_OUT,  16'h10F0},
    {O_LSEL, 16'h0F0F, O_LSEL, 16'h0F0F},
    {O_LPOL, 16'h3C3C, O_LPOL, 16'h3C3C},
    {O_RISE, 16'h00FF, O_RISE, 16'h00FF},
    {O_FALL, 16'hFF00, O_FALL, 16'hFF00},
    {O_MASK, 16'h5555, O_MASK, 16'h5555},
    {O_EN,   16'hAAAA, O_EN,   16'hAAAA},
    {8'h24,  16'hFFFF, 8'h24,  16'h0000},
    {8'h3C,  16'hFFFF, O_SET,  16'h0000}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
  logic [7:0]  paddr = '0;
  logic [15:0] pwdata = '0;
  logic [15:0] prdata;
  logic [15:0] pin_in = '0;
  logic [15:0] pin_out, pin_oe;
  logic        irq_out;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] rd;

  gpio_irq_port u0 (
    .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pin_in(pin_in),
    .pin_out(pin_out), .pin_oe(pin_oe), .irq_out(irq_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input logic [7:0] a, input logic [15:0] d);
    @(negedge clk); psel = 1; pwrite = 1; paddr = a; pwdata = d; penable = 0;
    @(negedge clk); penable = 1;
    @(negedge clk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [15:0] d);
    @(negedge clk); psel = 1; pwrite = 0; paddr = a; penable = 0;
    @(negedge clk); penable = 1;
    #1 d = prdata;
    @(negedge clk); psel = 0; penable = 0;
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_pins(input logic [15:0] v);
    @(negedge clk); pin_in = v;
    wait_clk(5);
  endtask

  initial begin
    wait_clk(3);
    rst_n = 1'b1;
    wait_clk(2);

    // R1 reset state
    check("R1 pin_oe", pin_oe, 16'h0000);
    check("R1 pin_out", pin_out, 16'h0000);
    check("R1 irq_out", {15'd0, irq_out}, 16'h0000);
    bus_rd(O_MASK, rd); check("R1 mask", rd, 16'hFFFF);
    bus_rd(O_EN, rd);   check("R1 enable", rd, 16'h0000);
    bus_rd(O_PEND, rd); check("R1 pend", rd, 16'h0000);

    // Register table: R2 R3 R4 R11
    for (int i = 0; i < NVEC; i++) begin
      bus_wr(VEC[i][47:40], VEC[i][39:24]);
      bus_rd(VEC[i][23:16], rd);
      check($sformatf("R2 R3 R4 R11 vector %0d", i), rd, VEC[i][15:0]);
    end
    check("R2 pin_oe", pin_oe, 16'hA5A5);
    check("R3 pin_out", pin_out, 16'h10F0);
    bus_rd(O_ACK, rd); check("R11 ack reads zero", rd, 16'h0000);

    // Clean interrupt setup
    bus_wr(O_RISE, 16'h0000); bus_wr(O_FALL, 16'h0000);
    bus_wr(O_LSEL, 16'h0000); bus_wr(O_LPOL, 16'h0000);
    bus_wr(O_ACK, 16'hFFFF);
    bus_wr(O_MASK, 16'h0000); bus_wr(O_EN, 16'hFFFF);
    bus_rd(O_PEND, rd); check("R6 no enables no pend", rd, 16'h0000);

    // R4 input sampling
    set_pins(16'h5A3C);
    bus_rd(O_PINS, rd); check("R4 input word", rd, 16'h5A3C);
    set_pins(16'h0000);
    bus_rd(O_PEND, rd); check("R6 edges ignored when disarmed", rd, 16'h0000);

    // R6 R7 rising edge on pin0
    bus_wr(O_RISE, 16'h0007); bus_wr(O_FALL, 16'h0006);
    set_pins(16'h0001);
    bus_rd(O_PEND, rd); check("R6 rise pin0", rd, 16'h0001);
    check("R10 irq high", {15'd0, irq_out}, 16'h0001);
    set_pins(16'h0000);
    bus_rd(O_PEND, rd); check("R7 event held after fall", rd, 16'h0001);
    bus_wr(O_ACK, 16'h0000);
    bus_rd(O_PEND, rd); check("R7 zero ack keeps event", rd, 16'h0001);
    bus_wr(O_ACK, 16'h0001);
    bus_rd(O_PEND, rd); check("R7 ack clears", rd, 16'h0000);
    check("R10 irq low", {15'd0, irq_out}, 16'h0000);

    // R6 falling only on pin1 (rise disabled for bit1? bit1 has both)
    bus_wr(O_RISE, 16'h0005);
    set_pins(16'h0002);
    bus_rd(O_PEND, rd); check("R6 fall-only ignores rise", rd, 16'h0000);
    set_pins(16'h0000);
    bus_rd(O_PEND, rd); check("R6 fall pin1", rd, 16'h0002);
    bus_wr(O_ACK, 16'h0002);

    // R6 both edges on pin2
    set_pins(16'h0004);
    bus_rd(O_PEND, rd); check("R6 both rise pin2", rd, 16'h0004);
    bus_wr(O_ACK, 16'h0004);
    bus_rd(O_PEND, rd); check("R7 pin2 cleared", rd, 16'h0000);
    set_pins(16'h0000);
    bus_rd(O_PEND, rd); check("R6 both fall pin2", rd, 16'h0004);
    bus_wr(O_ACK, 16'h0004);

    // R8 edge and clear in the same cycle
    set_pins(16'h0004);
    @(negedge clk); pin_in = 16'h0000;
    bus_wr(O_ACK, 16'h0004);
    wait_clk(3);
    bus_rd(O_PEND, rd); check("R8 new edge beats clear", rd, 16'h0004);
    bus_wr(O_ACK, 16'h0004);
    bus_rd(O_PEND, rd); check("R8 later clear", rd, 16'h0000);

    // R5 level high on pin3, level low on pin4
    bus_wr(O_LSEL, 16'h0008); bus_wr(O_LPOL, 16'h0008);
    set_pins(16'h0008);
    bus_rd(O_PEND, rd); check("R5 level high", rd, 16'h0008);
    set_pins(16'h0000);
    bus_rd(O_PEND, rd); check("R5 level drops without ack", rd, 16'h0000);
    check("R10 irq drops", {15'd0, irq_out}, 16'h0000);
    bus_wr(O_LSEL, 16'h0018);
    wait_clk(2);
    bus_rd(O_PEND, rd); check("R5 level low", rd, 16'h0010);
    set_pins(16'h0010);
    bus_rd(O_PEND, rd); check("R5 level low released", rd, 16'h0000);
    bus_wr(O_LSEL, 16'h0000);
    set_pins(16'h0000);
    bus_wr(O_ACK, 16'hFFFF);

    // R9 mask and enable gating on a latched event
    bus_wr(O_MASK, 16'h0001);
    set_pins(16'h0001);
    bus_rd(O_PEND, rd); check("R9 masked hidden", rd, 16'h0000);
    check("R9 masked no irq", {15'd0, irq_out}, 16'h0000);
    bus_wr(O_MASK, 16'h0000);
    bus_rd(O_PEND, rd); check("R9 unmasked visible", rd, 16'h0001);
    bus_wr(O_EN, 16'hFFFE);
    bus_rd(O_PEND, rd); check("R9 disabled hidden", rd, 16'h0000);
    check("R9 disabled no irq", {15'd0, irq_out}, 16'h0000);
    bus_wr(O_EN, 16'hFFFF);
    bus_rd(O_PEND, rd); check("R9 enabled visible", rd, 16'h0001);
    check("R10 irq again", {15'd0, irq_out}, 16'h0001);
    bus_wr(O_ACK, 16'h0001);
    wait_clk(2);
    check("R10 irq after ack", {15'd0, irq_out}, 16'h0000);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 100000);
    n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule